// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block runs once after reset and fills the timing controller's register bank before any timing generation is allowed to start. It talks to an external byte-wide configuration memory through a simple read port. The block raises a request with an address and holds both until a one-cycle response pulse returns the byte. Its first read is a presence probe. A zero byte means a programmed memory is attached, and the block then walks a fixed address map. Any other byte, or a read that never gets an answer, makes the block load its built-in default values instead.

The register bank holds one set of timing registers per general-purpose output channel: a 10-bit pixel start, 11-bit pixel count, 11-bit line start, 11-bit line count and a 5-bit control field. It also holds 11-bit horizontal and vertical back-porch values and an 8-bit output enable/polarity byte. Registers wider than a byte are built from two neighbouring addresses, with the low byte at the lower address. Bits of the pair above the register width are dropped. All register outputs read zero until the `done` output goes high, and `done` then stays high.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: During and right after reset, `busy` is 1 and `done` is 0, and the first request is issued at address 0x00 (the presence probe).
- R2: A probe byte of 0x00 starts a load from the memory. Any other probe byte loads the defaults, and no further read is issued.
- R3: A memory load reads each address exactly once, in increasing order. First come the channel bytes 0x81 up to 0x81+9*NUM_CH-1, with highest channel first and 9 bytes per channel. Then come 0xD7 to 0xDB. No address from 0xDC to 0xFF is ever read.
- R4: Within a channel's 9 bytes the layout is: pixel start (offsets 0,1), pixel count (2,3), line start (4,5), line count (6,7), control (8). Horizontal back porch is at 0xD7/0xD8, vertical back porch at 0xD9/0xDA, and the enable/polarity byte at 0xDB. Every pair is little-endian.
- R5: Bits of an assembled pair above the register width (6 bits for pixel start, 5 bits for the 11-bit registers) are ignored, and so are bits 7:5 of the control byte.
- R6: The default values are: pixel start 8*ch, pixel count 128, line start ch, line count 768, control ch (5 bits), horizontal back porch 100, vertical back porch 35, enable/polarity 0x03.
- R7: When a request waits TIMEOUT cycles without a response, the memory counts as absent and the defaults are loaded, replacing any values already loaded.
- R8: All register outputs are zero while `done` is 0. `done` rises exactly one cycle after the last register write, then stays 1 with `busy` at 0 and no further requests.
- R9: `oclk_en` equals bit 0 and `oclk_pol` equals bit 1 of the loaded enable/polarity byte.
- R10: `rd_req` stays high and `rd_addr` stays stable from the start of a request until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 8 | Byte address of the request |
| rd_valid | input | 1 | One-cycle response pulse |
| rd_data | input | 8 | Response byte |
| busy | output | 1 | Load in progress |
| done | output | 1 | Bank loaded; releases timing generation |
| gpo_pstart | output | 10*NUM_CH | Pixel start per channel |
| gpo_pcount | output | 11*NUM_CH | Pixel count per channel |
| gpo_lstart | output | 11*NUM_CH | Line start per channel |
| gpo_lcount | output | 11*NUM_CH | Line count per channel |
| gpo_ctrl | output | 5*NUM_CH | Control field per channel |
| hbp | output | 11 | Horizontal back porch |
| vbp | output | 11 | Vertical back porch |
| oe_ctrl | output | 8 | Output enable/polarity byte |
| oclk_en | output | 1 | Odd output clock enable |
| oclk_pol | output | 1 | Odd output clock polarity |

## Verification
The properties assume that `rd_valid` pulses for a single cycle, only while `rd_req` is high, and at most once per request. The bench's memory model keeps to this. It answers only a request it saw at a falling edge, waits a chosen latency, and drives the byte for exactly one cycle. To trigger the timeout, the stimulus does not send a reply that breaks the protocol. It stops answering, either from the probe onward or after a fixed number of replies.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int PSTART_W     = 10;
    localparam int CNT_W        = 11;
    localparam int CTRL_W       = 5;
    localparam int OE_W         = 8;
    localparam int BYTES_PER_CH = 9;
    localparam int TAIL_BYTES   = 5;

    typedef enum logic [2:0] {
        ST_PROBE,
        ST_LOAD,
        ST_DFLT,
        ST_FIN,
        ST_DONE
    } ld_state_e;

    typedef enum logic [2:0] {
        FLD_PSTART = 3'd0,
        FLD_PCOUNT = 3'd1,
        FLD_LSTART = 3'd2,
        FLD_LCOUNT = 3'd3,
        FLD_CTRL   = 3'd4,
        FLD_HBP    = 3'd5,
        FLD_VBP    = 3'd6,
        FLD_OE     = 3'd7
    } fld_e;

    // Role of one byte in the address walk
    typedef struct packed {
        fld_e fld;
        logic hi;      // upper byte of a pair
        logic single;  // one-byte register
    } byte_role_t;

    // Register write produced by pair assembly
    typedef struct packed {
        logic        vld;
        fld_e        fld;
        logic [7:0]  ch;
        logic [15:0] val;
    } reg_wr_t;

    function automatic byte_role_t byte_role(input logic [3:0] idx, input logic tail);
        byte_role_t r;
        r.hi     = idx[0];
        r.single = 1'b0;
        if (!tail) begin
            if (idx == 4'd8) begin
                r.fld    = FLD_CTRL;
                r.single = 1'b1;
                r.hi     = 1'b0;
            end else begin
                r.fld = fld_e'({1'b0, idx[2:1]});
            end
        end else begin
            case (idx[2:1])
                2'd0:    r.fld = FLD_HBP;
                2'd1:    r.fld = FLD_VBP;
                default: begin
                    r.fld    = FLD_OE;
                    r.single = 1'b1;
                    r.hi     = 1'b0;
                end
            endcase
        end
        return r;
    endfunction

    function automatic logic [PSTART_W-1:0] dflt_pstart(input int ch);
        return PSTART_W'(8 * ch);
    endfunction

    function automatic logic [CNT_W-1:0] dflt_pcount(input int ch);
        return (ch >= 0) ? CNT_W'(128) : '0;
    endfunction

    function automatic logic [CNT_W-1:0] dflt_lstart(input int ch);
        return CNT_W'(ch);
    endfunction

    function automatic logic [CNT_W-1:0] dflt_lcount(input int ch);
        return (ch >= 0) ? CNT_W'(768) : '0;
    endfunction

    function automatic logic [CTRL_W-1:0] dflt_ctrl(input int ch);
        return CTRL_W'(ch);
    endfunction

    localparam logic [CNT_W-1:0] DFLT_HBP = CNT_W'(100);
    localparam logic [CNT_W-1:0] DFLT_VBP = CNT_W'(35);
    localparam logic [OE_W-1:0]  DFLT_OE  = 8'h03;

endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int         NUM_CH     = 9,
    parameter logic [7:0] PROBE_ADDR = 8'h00,
    parameter logic [7:0] GPO_BASE   = 8'h81,
    parameter logic [7:0] TAIL_BASE  = 8'hD7,
    parameter int         TIMEOUT    = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_valid,
    input  logic [7:0] rd_data,
    output logic       rd_req,
    output logic [7:0] rd_addr,
    output logic       accept,
    output byte_role_t role,
    output logic [7:0] ch_idx,
    output logic       dflt_load,
    output logic       busy,
    output logic       done
);

    localparam int WAIT_W = $clog2(TIMEOUT + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT - 1);
    localparam logic [7:0] LAST_SLOT = 8'(NUM_CH - 1);
    localparam logic [3:0] LAST_CH_BYTE = 4'(BYTES_PER_CH - 1);
    localparam logic [3:0] LAST_TAIL_BYTE = 4'(TAIL_BYTES - 1);

    ld_state_e         state_q;
    logic [7:0]        addr_q;
    logic [3:0]        byte_q;
    logic [7:0]        slot_q;
    logic              tail_q;
    logic [WAIT_W-1:0] wait_q;
    logic              timed_out;

    always_comb begin
        rd_req    = (state_q == ST_PROBE) || (state_q == ST_LOAD);
        rd_addr   = addr_q;
        accept    = (state_q == ST_LOAD) && rd_valid;
        role      = byte_role(byte_q, tail_q);
        ch_idx    = tail_q ? 8'd0 : (LAST_SLOT - slot_q);
        dflt_load = (state_q == ST_DFLT);
        busy      = (state_q != ST_DONE);
        done      = (state_q == ST_DONE);
        timed_out = rd_req && !rd_valid && (wait_q == WAIT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (!rd_req || rd_valid) begin
            wait_q <= '0;
        end else begin
            wait_q <= wait_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PROBE;
            addr_q  <= PROBE_ADDR;
            byte_q  <= '0;
            slot_q  <= '0;
            tail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_PROBE: begin
                    if (rd_valid) begin
                        if (rd_data == 8'h00) begin
                            state_q <= ST_LOAD;
                            addr_q  <= GPO_BASE;
                            byte_q  <= '0;
                            slot_q  <= '0;
                            tail_q  <= 1'b0;
                        end else begin
                            state_q <= ST_DFLT;
                        end
                    end else if (timed_out) begin
                        state_q <= ST_DFLT;
                    end
                end
                ST_LOAD: begin
                    if (rd_valid) begin
                        if (tail_q && byte_q == LAST_TAIL_BYTE) begin
                            state_q <= ST_FIN;
                        end else if (!tail_q && byte_q == LAST_CH_BYTE) begin
                            byte_q <= '0;
                            if (slot_q == LAST_SLOT) begin
                                tail_q <= 1'b1;
                                addr_q <= TAIL_BASE;
                            end else begin
                                slot_q <= slot_q + 1'b1;
                                addr_q <= addr_q + 1'b1;
                            end
                        end else begin
                            byte_q <= byte_q + 1'b1;
                            addr_q <= addr_q + 1'b1;
                        end
                    end else if (timed_out) begin
                        state_q <= ST_DFLT;
                    end
                end
                ST_DFLT: state_q <= ST_FIN;
                ST_FIN:  state_q <= ST_DONE;
                default: state_q <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/cfgld_pair.sv
module cfgld_pair
    import cfgld_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  byte_role_t role,
    input  logic [7:0] ch_idx,
    input  logic [7:0] rd_data,
    output reg_wr_t    wr
);

    logic [7:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (accept && !role.single && !role.hi) begin
            lo_q <= rd_data;
        end
    end

    always_comb begin
        wr.vld = accept && (role.single || role.hi);
        wr.fld = role.fld;
        wr.ch  = ch_idx;
        wr.val = role.single ? {8'h00, rd_data} : {rd_data, lo_q};
    end

endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank
    import cfgld_pkg::*;
#(
    parameter int NUM_CH = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  reg_wr_t                    wr,
    input  logic                       dflt_load,
    input  logic                       done,
    output logic [NUM_CH*PSTART_W-1:0] gpo_pstart,
    output logic [NUM_CH*CNT_W-1:0]    gpo_pcount,
    output logic [NUM_CH*CNT_W-1:0]    gpo_lstart,
    output logic [NUM_CH*CNT_W-1:0]    gpo_lcount,
    output logic [NUM_CH*CTRL_W-1:0]   gpo_ctrl,
    output logic [CNT_W-1:0]           hbp,
    output logic [CNT_W-1:0]           vbp,
    output logic [OE_W-1:0]            oe_ctrl
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [PSTART_W-1:0] ps_q;
        logic [CNT_W-1:0]    pc_q;
        logic [CNT_W-1:0]    ls_q;
        logic [CNT_W-1:0]    lc_q;
        logic [CTRL_W-1:0]   ct_q;
        logic                hit;

        assign hit = wr.vld && (wr.ch == 8'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                ps_q <= '0;
                pc_q <= '0;
                ls_q <= '0;
                lc_q <= '0;
                ct_q <= '0;
            end else if (dflt_load) begin
                ps_q <= dflt_pstart(c);
                pc_q <= dflt_pcount(c);
                ls_q <= dflt_lstart(c);
                lc_q <= dflt_lcount(c);
                ct_q <= dflt_ctrl(c);
            end else if (hit) begin
                case (wr.fld)
                    FLD_PSTART: ps_q <= wr.val[PSTART_W-1:0];
                    FLD_PCOUNT: pc_q <= wr.val[CNT_W-1:0];
                    FLD_LSTART: ls_q <= wr.val[CNT_W-1:0];
                    FLD_LCOUNT: lc_q <= wr.val[CNT_W-1:0];
                    FLD_CTRL:   ct_q <= wr.val[CTRL_W-1:0];
                    default: ;
                endcase
            end
        end

        assign gpo_pstart[c*PSTART_W +: PSTART_W] = done ? ps_q : '0;
        assign gpo_pcount[c*CNT_W +: CNT_W]       = done ? pc_q : '0;
        assign gpo_lstart[c*CNT_W +: CNT_W]       = done ? ls_q : '0;
        assign gpo_lcount[c*CNT_W +: CNT_W]       = done ? lc_q : '0;
        assign gpo_ctrl[c*CTRL_W +: CTRL_W]       = done ? ct_q : '0;
    end

    logic [CNT_W-1:0] hbp_q;
    logic [CNT_W-1:0] vbp_q;
    logic [OE_W-1:0]  oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hbp_q <= '0;
            vbp_q <= '0;
            oe_q  <= '0;
        end else if (dflt_load) begin
            hbp_q <= DFLT_HBP;
            vbp_q <= DFLT_VBP;
            oe_q  <= DFLT_OE;
        end else if (wr.vld) begin
            case (wr.fld)
                FLD_HBP: hbp_q <= wr.val[CNT_W-1:0];
                FLD_VBP: vbp_q <= wr.val[CNT_W-1:0];
                FLD_OE:  oe_q  <= wr.val[OE_W-1:0];
                default: ;
            endcase
        end
    end

    assign hbp     = done ? hbp_q : '0;
    assign vbp     = done ? vbp_q : '0;
    assign oe_ctrl = done ? oe_q  : '0;

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int         NUM_CH     = 9,
    parameter logic [7:0] PROBE_ADDR = 8'h00,
    parameter logic [7:0] GPO_BASE   = 8'h81,
    parameter logic [7:0] TAIL_BASE  = 8'hD7,
    parameter int         TIMEOUT    = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       rd_req,
    output logic [7:0]                 rd_addr,
    input  logic                       rd_valid,
    input  logic [7:0]                 rd_data,
    output logic                       busy,
    output logic                       done,
    output logic [NUM_CH*PSTART_W-1:0] gpo_pstart,
    output logic [NUM_CH*CNT_W-1:0]    gpo_pcount,
    output logic [NUM_CH*CNT_W-1:0]    gpo_lstart,
    output logic [NUM_CH*CNT_W-1:0]    gpo_lcount,
    output logic [NUM_CH*CTRL_W-1:0]   gpo_ctrl,
    output logic [CNT_W-1:0]           hbp,
    output logic [CNT_W-1:0]           vbp,
    output logic [OE_W-1:0]            oe_ctrl,
    output logic                       oclk_en,
    output logic                       oclk_pol
);

    logic       accept;
    byte_role_t role;
    logic [7:0] ch_idx;
    logic       dflt_load;
    reg_wr_t    wr;

    cfgld_seq #(
        .NUM_CH    (NUM_CH),
        .PROBE_ADDR(PROBE_ADDR),
        .GPO_BASE  (GPO_BASE),
        .TAIL_BASE (TAIL_BASE),
        .TIMEOUT   (TIMEOUT)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .accept   (accept),
        .role     (role),
        .ch_idx   (ch_idx),
        .dflt_load(dflt_load),
        .busy     (busy),
        .done     (done)
    );

    cfgld_pair pair_i (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .role   (role),
        .ch_idx (ch_idx),
        .rd_data(rd_data),
        .wr     (wr)
    );

    cfgld_bank #(.NUM_CH(NUM_CH)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .dflt_load (dflt_load),
        .done      (done),
        .gpo_pstart(gpo_pstart),
        .gpo_pcount(gpo_pcount),
        .gpo_lstart(gpo_lstart),
        .gpo_lcount(gpo_lcount),
        .gpo_ctrl  (gpo_ctrl),
        .hbp       (hbp),
        .vbp       (vbp),
        .oe_ctrl   (oe_ctrl)
    );

    assign oclk_en  = oe_ctrl[0];
    assign oclk_pol = oe_ctrl[1];

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk
    import cfgld_pkg::*;
#(
    parameter int         NUM_CH     = 9,
    parameter logic [7:0] GPO_BASE   = 8'h81,
    parameter logic [7:0] TAIL_BASE  = 8'hD7,
    parameter int         TIMEOUT    = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       rd_req,
    input logic [7:0]                 rd_addr,
    input logic                       rd_valid,
    input logic                       busy,
    input logic                       done,
    input logic [NUM_CH*PSTART_W-1:0] gpo_pstart,
    input logic [NUM_CH*CNT_W-1:0]    gpo_lcount,
    input logic [CNT_W-1:0]           hbp,
    input logic [CNT_W-1:0]           vbp,
    input logic [OE_W-1:0]            oe_ctrl
);

    localparam logic [8:0] CH_END   = 9'(GPO_BASE) + 9'(BYTES_PER_CH * NUM_CH);
    localparam logic [8:0] TAIL_END = 9'(TAIL_BASE) + 9'(TAIL_BYTES);

    logic [15:0] wait_c;

    always_ff @(posedge clk) begin
        if (rst) wait_c <= '0;
        else if (rd_req && !rd_valid) wait_c <= wait_c + 1'b1;
        else wait_c <= '0;
    end

    // R1: busy and done are complementary
    assert_busy_done_R1: assert property (@(posedge clk) disable iff (rst)
        busy != done);

    // R3: only the probe, channel and tail addresses are requested
    assert_addr_window_R3: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr == 8'h00)
                || ({1'b0, rd_addr} >= 9'(GPO_BASE) && {1'b0, rd_addr} < CH_END)
                || ({1'b0, rd_addr} >= 9'(TAIL_BASE) && {1'b0, rd_addr} < TAIL_END));

    // R7: a request never waits longer than the timeout
    assert_wait_bound_R7: assert property (@(posedge clk) disable iff (rst)
        wait_c <= 16'(TIMEOUT));

    // R8: done is sticky, and no request once done
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_no_req_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);

    // R8: register outputs are held at zero before done
    assert_zero_before_done_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (hbp == '0 && vbp == '0 && oe_ctrl == '0
                   && gpo_pstart == '0 && gpo_lcount == '0));

    // R8: done rises only after a cycle without a request
    assert_done_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !$past(rd_req));

    // R10: a pending request holds its address
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && wait_c < 16'(TIMEOUT - 1)) |=> (rd_req && $stable(rd_addr)));

endmodule

bind eeprom_cfg_loader cfgld_chk #(
    .NUM_CH   (NUM_CH),
    .GPO_BASE (GPO_BASE),
    .TAIL_BASE(TAIL_BASE),
    .TIMEOUT  (TIMEOUT)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .done      (done),
    .gpo_pstart(gpo_pstart),
    .gpo_lcount(gpo_lcount),
    .hbp       (hbp),
    .vbp       (vbp),
    .oe_ctrl   (oe_ctrl)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module eeprom_cfg_loader_tb_top;

    localparam int NCH  = 9;
    localparam int TOUT = 64;
    localparam int NRD  = 1 + 9 * NCH + 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_req;
    logic [7:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [7:0] rd_data = '0;
    logic busy, done;
    logic [NCH*10-1:0] gpo_pstart;
    logic [NCH*11-1:0] gpo_pcount, gpo_lstart, gpo_lcount;
    logic [NCH*5-1:0]  gpo_ctrl;
    logic [10:0] hbp, vbp;
    logic [7:0]  oe_ctrl;
    logic oclk_en, oclk_pol;

    always #10 clk = ~clk;

    eeprom_cfg_loader #(.NUM_CH(NCH), .TIMEOUT(TOUT)) dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .gpo_pstart(gpo_pstart), .gpo_pcount(gpo_pcount), .gpo_lstart(gpo_lstart),
        .gpo_lcount(gpo_lcount), .gpo_ctrl(gpo_ctrl), .hbp(hbp), .vbp(vbp),
        .oe_ctrl(oe_ctrl), .oclk_en(oclk_en), .oclk_pol(oclk_pol)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mem [256];
    int lat = 0;
    bit resp_on = 1'b1;
    int resp_limit = -1;
    int resp_cnt = 0;
    int cyc = 0;
    int nreads = 0;
    logic [7:0] rlog [128];
    int last_acc = 0;
    int done_cyc = -1;
    int zero_viol = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // memory model: answer an observed request after lat cycles
    initial forever begin
        logic [7:0] a;
        @(negedge clk);
        rd_valid = 1'b0;
        if (!rst && rd_req && resp_on && (resp_limit < 0 || resp_cnt < resp_limit)) begin
            a = rd_addr;
            repeat (lat) @(negedge clk);
            rd_data  = mem[a];
            rd_valid = 1'b1;
            resp_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst && rd_req && rd_valid) begin
            if (nreads < 128) rlog[nreads] = rd_addr;
            nreads++;
            last_acc = cyc;
        end
        if (!rst && done && done_cyc < 0) done_cyc = cyc;
    end

    always @(negedge clk) begin
        if (!rst && !done && (gpo_pstart != '0 || gpo_pcount != '0 || gpo_lstart != '0
            || gpo_lcount != '0 || gpo_ctrl != '0 || hbp != '0 || vbp != '0 || oe_ctrl != '0))
            zero_viol++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic fill_mem(input int seed, input logic [7:0] probe);
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + seed * 11 + (a >> 3)) & 8'hFF);
        mem[0] = probe;
        mem[8'h82] = 8'hFF; // R5: upper bits of pixel start set
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        resp_cnt = 0; nreads = 0; done_cyc = -1; zero_viol = 0; last_acc = 0;
        rst = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_eeprom_values();
        for (int j = 0; j < NCH; j++) begin
            int ch = NCH - 1 - j;
            int b  = 8'h81 + 9 * j;
            logic [15:0] ps = {mem[b+1], mem[b]};
            logic [15:0] pc = {mem[b+3], mem[b+2]};
            logic [15:0] ls = {mem[b+5], mem[b+4]};
            logic [15:0] lc = {mem[b+7], mem[b+6]};
            chk(gpo_pstart[ch*10 +: 10] == ps[9:0], "R4 R5 pixel start", 32'(gpo_pstart[ch*10 +: 10]), 32'(ps[9:0]));
            chk(gpo_pcount[ch*11 +: 11] == pc[10:0], "R4 pixel count", 32'(gpo_pcount[ch*11 +: 11]), 32'(pc[10:0]));
            chk(gpo_lstart[ch*11 +: 11] == ls[10:0], "R4 line start", 32'(gpo_lstart[ch*11 +: 11]), 32'(ls[10:0]));
            chk(gpo_lcount[ch*11 +: 11] == lc[10:0], "R4 R5 line count", 32'(gpo_lcount[ch*11 +: 11]), 32'(lc[10:0]));
            chk(gpo_ctrl[ch*5 +: 5] == mem[b+8][4:0], "R5 control", 32'(gpo_ctrl[ch*5 +: 5]), 32'(mem[b+8][4:0]));
        end
        chk(hbp == {mem[8'hD8][2:0], mem[8'hD7]}, "R4 hbp", 32'(hbp), 32'({mem[8'hD8][2:0], mem[8'hD7]}));
        chk(vbp == {mem[8'hDA][2:0], mem[8'hD9]}, "R4 vbp", 32'(vbp), 32'({mem[8'hDA][2:0], mem[8'hD9]}));
        chk(oe_ctrl == mem[8'hDB], "R4 enable byte", 32'(oe_ctrl), 32'(mem[8'hDB]));
        chk(oclk_en == mem[8'hDB][0], "R9 oclk_en", 32'(oclk_en), 32'(mem[8'hDB][0]));
        chk(oclk_pol == mem[8'hDB][1], "R9 oclk_pol", 32'(oclk_pol), 32'(mem[8'hDB][1]));
    endtask

    task automatic check_defaults(input string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            chk(gpo_pstart[ch*10 +: 10] == 10'(8 * ch), {tag, " R6 pixel start"}, 32'(gpo_pstart[ch*10 +: 10]), 32'(8 * ch));
            chk(gpo_pcount[ch*11 +: 11] == 11'd128, {tag, " R6 pixel count"}, 32'(gpo_pcount[ch*11 +: 11]), 128);
            chk(gpo_lstart[ch*11 +: 11] == 11'(ch), {tag, " R6 line start"}, 32'(gpo_lstart[ch*11 +: 11]), 32'(ch));
            chk(gpo_lcount[ch*11 +: 11] == 11'd768, {tag, " R6 line count"}, 32'(gpo_lcount[ch*11 +: 11]), 768);
            chk(gpo_ctrl[ch*5 +: 5] == 5'(ch), {tag, " R6 control"}, 32'(gpo_ctrl[ch*5 +: 5]), 32'(ch));
        end
        chk(hbp == 11'd100, {tag, " R6 hbp"}, 32'(hbp), 100);
        chk(vbp == 11'd35, {tag, " R6 vbp"}, 32'(vbp), 35);
        chk(oe_ctrl == 8'h03, {tag, " R6 enable byte"}, 32'(oe_ctrl), 32'h03);
        chk(oclk_en && oclk_pol, {tag, " R9 clock bits"}, {oclk_pol, oclk_en}, 2'b11);
        chk(done && !busy && !rd_req, {tag, " R8 final handshake"}, {done, busy, rd_req}, 3'b100);
    endtask

    task automatic check_walk();
        bit ok = 1'b1;
        int first_bad = -1;
        chk(nreads == NRD, "R3 read count", 32'(nreads), 32'(NRD));
        for (int i = 0; i < NRD && i < nreads; i++) begin
            logic [7:0] e = (i == 0) ? 8'h00 : (i <= 9 * NCH) ? 8'(8'h81 + i - 1) : 8'(8'hD7 + i - 1 - 9 * NCH);
            if (rlog[i] != e && ok) begin ok = 1'b0; first_bad = i; end
        end
        chk(ok, "R3 address order", 32'(first_bad >= 0 ? rlog[first_bad] : 0), 32'(first_bad));
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(busy && !done, "R1 busy/done in reset", {busy, done}, 2'b10);
        chk(hbp == '0 && oe_ctrl == '0 && gpo_pstart == '0, "R8 zero in reset", 32'(oe_ctrl), 0);
        resp_on = 1'b0;
        do_reset();
        chk(rd_req && rd_addr == 8'h00, "R1 probe address", {rd_req, rd_addr}, 9'h100);
        resp_on = 1'b1;
    endtask

    task automatic t_eeprom(input int seed, input int l);
        fill_mem(seed, 8'h00);
        lat = l; resp_limit = -1; resp_on = 1'b1;
        do_reset();
        wait_done(2000);
        check_walk();
        check_eeprom_values();
        chk(done_cyc == last_acc + 2, "R8 done one cycle after last write", 32'(done_cyc), 32'(last_acc + 2));
        chk(zero_viol == 0, "R8 outputs zero before done", 32'(zero_viol), 0);
        chk(done && !busy && !rd_req, "R2 R8 final handshake", {done, busy, rd_req}, 3'b100);
    endtask

    task automatic t_absent();
        fill_mem(5, 8'h01);
        lat = 1; resp_limit = -1; resp_on = 1'b1;
        do_reset();
        wait_done(200);
        repeat (5) @(negedge clk);
        chk(nreads == 1, "R2 only the probe is read", 32'(nreads), 1);
        check_defaults("absent");
        chk(zero_viol == 0, "R8 outputs zero before done", 32'(zero_viol), 0);
    endtask

    task automatic t_timeout_probe();
        int t0;
        fill_mem(7, 8'h00);
        resp_on = 1'b0; resp_limit = -1;
        do_reset();
        t0 = cyc;
        wait_done(TOUT + 20);
        chk(done, "R7 probe timeout finishes", 32'(done), 1);
        chk(done_cyc - t0 <= TOUT + 4 && done_cyc - t0 >= TOUT, "R7 timeout length", 32'(done_cyc - t0), 32'(TOUT + 3));
        check_defaults("timeout probe");
        resp_on = 1'b1;
    endtask

    task automatic t_timeout_mid();
        fill_mem(9, 8'h00);
        lat = 0; resp_limit = 20; resp_on = 1'b1;
        do_reset();
        wait_done(TOUT + 200);
        chk(nreads == 20, "R7 reads before stall", 32'(nreads), 20);
        check_defaults("timeout mid");
        chk(zero_viol == 0, "R8 outputs zero before done", 32'(zero_viol), 0);
        resp_limit = -1;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = '0;
        t_reset_state();
        t_eeprom(1, 0);
        t_eeprom(3, 3);   // R10: requests held over a multi-cycle latency
        t_absent();
        t_timeout_probe();
        t_timeout_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule